// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction should fire. It takes two operands and a five-bit condition mask. It works out every relation between the operands at the same time: signed less and greater, equality, and unsigned less and greater. The result is true when any relation that the mask enables holds.

A width-select input picks the comparison size. In word mode only the low halves of the operands are compared, and the sign comes from the top bit of that half. In doubleword mode the full operands are compared. The result is registered and appears one cycle after a valid request, together with the program-exception subcause code for a trap. The execute stage uses these two outputs to start exception entry.

Top module: `trap_cmp_top`

## Requirements
- R1: Mask bit 4 (value 5'h10) enables a trap when operand A is less than operand B as signed numbers.
- R2: Mask bit 3 (value 5'h08) enables a trap when A is greater than B as signed numbers.
- R3: Mask bit 2 (value 5'h04) enables a trap when A equals B; for any operand pair exactly one of signed-less, signed-greater and equal holds.
- R4: Mask bit 1 (value 5'h02) enables a trap when A is below B as unsigned numbers, and mask bit 0 (value 5'h01) enables a trap when A is above B as unsigned numbers.
- R5: The trap fires when at least one enabled relation is true. Relations whose mask bit is clear have no effect.
- R6: With `word_mode`=1, only bits 31:0 of each operand are compared, with bit 31 as the sign. Bits 63:32 have no effect on the result.
- R7: With `word_mode`=0, all 64 bits of each operand are compared, with bit 63 as the sign.
- R8: `trap_req` is registered. It reflects the request presented one clock edge earlier, and it is 0 after any cycle in which `in_valid` was 0.
- R9: `trap_cause` equals the trap subcause code 4'h2 whenever `trap_req` is 1, and equals 4'h0 otherwise.
- R10: A mask of 5'h00 never traps. A mask of 5'h1F traps for every operand pair.
- R11: While `rst_n` is low, `trap_req` and `trap_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A trap instruction is presented this cycle |
| word_mode | input | 1 | 1: compare low 32 bits; 0: compare all 64 bits |
| cond_mask | input | 5 | Enabled relations: bit4 slt, bit3 sgt, bit2 eq, bit1 ult, bit0 ugt |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| trap_req | output | 1 | Registered trap request |
| trap_cause | output | 4 | Program-exception subcause, 4'h2 on a trap |

## Verification
Some properties are checked on every cycle:
- The signed relations are trichotomous.
- The unsigned relations are mutually exclusive and agree with equality.
- Word-mode extension fills the upper bits correctly.
- The cause code follows the request.
- An idle cycle, a zero mask and a full mask each give the fixed result on the next cycle.

Other behaviour can only be shown by the bench's operand scenarios:
- Whether a given mask bit selects the correct relation.
- Whether the upper bits are ignored in word mode but counted in doubleword mode.
- Where the signed and unsigned orderings disagree.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    localparam int COND_W = 5;

    // Field order matches the mask bit order: slt is bit 4, ugt is bit 0.
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_t;

endpackage

// File: rtl/trap_opnd_ext.sv
module trap_opnd_ext #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic              word_mode,
    output logic [DATA_W-1:0] sx,
    output logic [DATA_W-1:0] zx
);
    localparam int HI_W = DATA_W - WORD_W;

    always_comb begin
        if (word_mode) begin
            sx = {{HI_W{opnd[WORD_W-1]}}, opnd[WORD_W-1:0]};
            zx = {{HI_W{1'b0}}, opnd[WORD_W-1:0]};
        end else begin
            sx = opnd;
            zx = opnd;
        end
    end

    // R6: in word mode the signed copy carries bit 31 through the upper half.
    always_comb begin
        if (!$isunknown({word_mode, opnd}) && word_mode) begin
            p_sign_fill_r6: assert (sx[DATA_W-1:WORD_W] == {HI_W{opnd[WORD_W-1]}}
                                    && zx[DATA_W-1:WORD_W] == '0);
        end
    end
endmodule

// File: rtl/trap_rel_unit.sv
module trap_rel_unit
    import trap_cmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] sx_a,
    input  logic [DATA_W-1:0] sx_b,
    input  logic [DATA_W-1:0] zx_a,
    input  logic [DATA_W-1:0] zx_b,
    output rel_t              rel
);
    always_comb begin
        rel.slt = $signed(sx_a) < $signed(sx_b);
        rel.sgt = $signed(sx_a) > $signed(sx_b);
        rel.eq  = zx_a == zx_b;
        rel.ult = zx_a < zx_b;
        rel.ugt = zx_a > zx_b;
    end

    always_comb begin
        if (!$isunknown({sx_a, sx_b, zx_a, zx_b})) begin
            // R3: exactly one signed ordering or equality holds.
            p_trichotomy_r3: assert ($countones({rel.slt, rel.sgt, rel.eq}) == 1);
            // R4: unsigned relations are exclusive and absent on equality.
            p_unsigned_excl_r4: assert ($countones({rel.ult, rel.ugt, rel.eq}) == 1);
        end
    end
endmodule

// File: rtl/trap_cmp_top.sv
module trap_cmp_top
    import trap_cmp_pkg::*;
#(
    parameter int                 DATA_W    = 64,
    parameter int                 WORD_W    = 32,
    parameter int                 CAUSE_W   = 4,
    parameter logic [CAUSE_W-1:0] TRAP_CODE = CAUSE_W'(2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               word_mode,
    input  logic [COND_W-1:0]  cond_mask,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause
);
    localparam int N_OPND = 2;

    typedef struct packed {
        logic               req;
        logic [CAUSE_W-1:0] cause;
    } out_st_t;

    logic [DATA_W-1:0] opnd_arr [N_OPND];
    logic [DATA_W-1:0] sx_arr   [N_OPND];
    logic [DATA_W-1:0] zx_arr   [N_OPND];
    rel_t              rel;
    out_st_t           st_d, st_q;

    assign opnd_arr[0] = opnd_a;
    assign opnd_arr[1] = opnd_b;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_ext
        trap_opnd_ext #(
            .DATA_W (DATA_W),
            .WORD_W (WORD_W)
        ) u_ext (
            .opnd      (opnd_arr[gi]),
            .word_mode (word_mode),
            .sx        (sx_arr[gi]),
            .zx        (zx_arr[gi])
        );
    end

    trap_rel_unit #(
        .DATA_W (DATA_W)
    ) u_rel (
        .sx_a (sx_arr[0]),
        .sx_b (sx_arr[1]),
        .zx_a (zx_arr[0]),
        .zx_b (zx_arr[1]),
        .rel  (rel)
    );

    always_comb begin
        st_d       = '0;
        st_d.req   = in_valid && ((cond_mask & COND_W'(rel)) != '0);
        st_d.cause = st_d.req ? TRAP_CODE : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_req   = st_q.req;
    assign trap_cause = st_q.cause;

    // R8: an idle cycle never yields a trap on the next cycle.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !trap_req);
    // R10: a zero mask never traps.
    p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '0) |=> !trap_req);
    // R10: a full mask always traps.
    p_full_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '1) |=> trap_req);
    // R9: cause code follows the request.
    p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_cause == TRAP_CODE);
    p_cause_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> trap_cause == '0);
endmodule

// File: tb/trap_cmp_top_bench.sv
module trap_cmp_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        word_mode = 1'b0;
    logic [4:0]  cond_mask = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        trap_req;
    logic [3:0]  trap_cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_cmp_top u_trap_cmp_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .word_mode  (word_mode),
        .cond_mask  (cond_mask),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .trap_req   (trap_req),
        .trap_cause (trap_cause)
    );

    typedef struct packed {
        logic        wm;
        logic [4:0]  m;
        logic [63:0] a;
        logic [63:0] b;
        logic        exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},                      // R1 -1 < 1 signed
        '{1'b0, 5'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},                      // R4 not below unsigned
        '{1'b0, 5'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},                      // R4 above unsigned
        '{1'b0, 5'h08, 64'h5, 64'h3, 1'b1},                                        // R2
        '{1'b0, 5'h08, 64'h3, 64'h5, 1'b0},                                        // R2
        '{1'b0, 5'h04, 64'h1234, 64'h1234, 1'b1},                                  // R3
        '{1'b0, 5'h04, 64'h1234, 64'h1235, 1'b0},                                  // R3
        '{1'b1, 5'h04, 64'hAAAA_AAAA_0000_0007, 64'h5555_5555_0000_0007, 1'b1},    // R6 upper ignored
        '{1'b0, 5'h04, 64'hAAAA_AAAA_0000_0007, 64'h5555_5555_0000_0007, 1'b0},    // R7 upper counted
        '{1'b1, 5'h10, 64'h0000_0000_8000_0000, 64'h0, 1'b1},                      // R6 bit31 sign
        '{1'b0, 5'h10, 64'h0000_0000_8000_0000, 64'h0, 1'b0},                      // R7 positive
        '{1'b1, 5'h01, 64'h0000_0000_8000_0000, 64'h1, 1'b1},                      // R6 unsigned word
        '{1'b0, 5'h18, 64'h7, 64'h7, 1'b0},                                        // R5 none enabled true
        '{1'b0, 5'h1C, 64'h7, 64'h7, 1'b1},                                        // R5 eq enabled
        '{1'b0, 5'h00, 64'h1, 64'h2, 1'b0},                                        // R10 zero mask
        '{1'b0, 5'h1F, 64'h1, 64'h2, 1'b1},                                        // R10 full mask
        '{1'b0, 5'h1F, 64'h9, 64'h9, 1'b1},                                        // R10 full mask equal
        '{1'b1, 5'h08, 64'h0000_0001_7FFF_FFFF, 64'h0000_0000_8000_0000, 1'b1}     // R6 max vs min word
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic present(input logic v, input logic wm, input logic [4:0] m,
                           input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid  = v;
        word_mode = wm;
        cond_mask = m;
        opnd_a    = a;
        opnd_b    = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(trap_req == 1'b0, "R11 reset req", 64'(trap_req), 64'h0);
        check(trap_cause == 4'h0, "R11 reset cause", 64'(trap_cause), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            present(1'b1, VECS[i].wm, VECS[i].m, VECS[i].a, VECS[i].b);
            check(trap_req == VECS[i].exp, $sformatf("R5 vector %0d", i),
                  64'(trap_req), 64'(VECS[i].exp));
            check(trap_cause == (VECS[i].exp ? 4'h2 : 4'h0), $sformatf("R9 vector %0d", i),
                  64'(trap_cause), VECS[i].exp ? 64'h2 : 64'h0);
        end

        // R8: invalid request with a full mask does not trap
        present(1'b0, 1'b0, 5'h1F, 64'h1, 64'h2);
        check(trap_req == 1'b0, "R8 invalid ignored", 64'(trap_req), 64'h0);

        // R8: one-cycle latency and drop on the next idle cycle
        present(1'b1, 1'b0, 5'h04, 64'h42, 64'h42);
        check(trap_req == 1'b1, "R8 one-cycle result", 64'(trap_req), 64'h1);
        in_valid = 1'b0;
        @(negedge clk);
        check(trap_req == 1'b0, "R8 drops after idle", 64'(trap_req), 64'h0);

        // R11: reset clears a pending trap
        present(1'b1, 1'b0, 5'h1F, 64'h0, 64'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check(trap_req == 1'b0, "R11 reset clears req", 64'(trap_req), 64'h0);
        check(trap_cause == 4'h0, "R11 reset clears cause", 64'(trap_cause), 64'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule